// File: doc/BRIEF.md
# Search-Mode Spectrum Integrator

This block sums the four correlation products of every frequency channel over a run of consecutive spectra and then sends out the integrated spectrum. The four products are the two self-power terms (XX, YY) and the real and imaginary parts of the cross term. Spectra arrive one channel per accepted beat, in ascending channel order. A start-of-spectrum marker travels with channel 0. The channel count is a parameter, and the running sums are held in on-chip registers.

Three runtime settings together set the output data rate. The first is how many spectra are summed per output, with a programmable lower bound applied on top. The second is how many most-significant bits of each 24-bit sum are kept. The third is how many of the four products are sent. A finished spectrum is copied into a separate output buffer. That buffer is drained one word per valid/ready handshake while the next period accumulates. If the buffer is still draining when a new finished spectrum is due, the new one is dropped and a sticky overflow flag is raised.

Top module: `srch_integrator`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `ovf_flag` are 0 and no words are produced.
- R2: An integration period covers N consecutive spectra, where N = max(`cfg_nint`, `cfg_min_nint`), with 0 treated as 1. At the end of the period, one integrated spectrum is output. Its words are the per-channel, per-product sums of those N spectra.
- R3: The lower bound `cfg_min_nint` is enforced: when `cfg_nint` is smaller, no output appears until `cfg_min_nint` spectra have been summed.
- R4: Inputs are sign-extended `IN_W`-bit values. Sums are 24-bit signed and saturate at +8388607 and at -8388608.
- R5: `cfg_trunc` code 0 outputs the full 24-bit sum. Code 1 outputs sum/256, rounded toward zero. Codes 2 and 3 output sum/65536, rounded toward zero. In every case the result is sign-extended into the 24-bit `out_data`.
- R6: `cfg_nprod` code 0 sends XX only. Code 1 sends XX then YY. Codes 2 and 3 send XX, YY, Re, Im in that order. Channels go out in ascending order, and `out_last` is 1 only on the final word of the spectrum.
- R7: The settings are captured at the start of a period. If the effective count, `cfg_trunc` or `cfg_nprod` differs from the captured value when a spectrum begins, the partial sums are discarded and a fresh period starts at that spectrum.
- R8: Beats with `in_valid` low are ignored. Beats without `in_sos` that arrive before the first start marker after reset are also ignored. Gaps between beats of a spectrum are allowed.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R10: If a period's last spectrum begins while the previous output is not fully drained, that integrated spectrum is dropped and `ovf_flag` is set. The flag stays 1 until reset, and later periods proceed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sos | input | 1 | Start of spectrum, set on channel 0 |
| in_xx | input | IN_W | XX product, signed |
| in_yy | input | IN_W | YY product, signed |
| in_re | input | IN_W | Real cross product, signed |
| in_im | input | IN_W | Imaginary cross product, signed |
| cfg_nint | input | CNT_W | Spectra per integration |
| cfg_min_nint | input | CNT_W | Lower bound on spectra per integration |
| cfg_trunc | input | 2 | Kept-bit selection code |
| cfg_nprod | input | 2 | Product-count selection code |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 24 | Truncated sum, sign-extended |
| out_last | output | 1 | Final word of a spectrum |
| ovf_flag | output | 1 | Sticky lost-spectrum flag |

## Verification
A wrong period counter or a missed settings change shows up as sums that are a whole multiple of one spectrum too large or too small. It can also show up as an output that comes one or more spectra early or late. Either is visible on the first word of the next spectrum sent out. Errors in saturation or rounding show only on the affected words. The bench therefore drives full-scale inputs for hundreds of spectra and mixes negative values under each truncation code. A buffer-occupancy error appears as extra words, missing words, or an `ovf_flag` that is wrong right after the second spectrum of a stalled run.

// File: rtl/srch_pkg.sv
// Package: shared word type and arithmetic helpers for the search integrator.
// Assumes two's-complement 24-bit sums.
package srch_pkg;
    localparam int ACC_W  = 24;
    localparam int N_PROD = 4;

    typedef logic signed [ACC_W-1:0] acc_t;

    // Saturating signed add of two sums.
    function automatic acc_t sat_add(input acc_t a, input acc_t b);
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (s[ACC_W] != s[ACC_W-1])
            return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        return s[ACC_W-1:0];
    endfunction

    // Keep the top bits selected by code, rounding toward zero, sign-extended.
    function automatic acc_t trunc_val(input acc_t v, input logic [1:0] code);
        logic signed [ACC_W:0] t;
        logic signed [ACC_W:0] sh;
        case (code)
            2'd0: return v;
            2'd1: begin
                t  = {v[ACC_W-1], v} + (v[ACC_W-1] ? 25'sd255 : 25'sd0);
                sh = t >>> 8;
                return sh[ACC_W-1:0];
            end
            default: begin
                t  = {v[ACC_W-1], v} + (v[ACC_W-1] ? 25'sd65535 : 25'sd0);
                sh = t >>> 16;
                return sh[ACC_W-1:0];
            end
        endcase
    endfunction
endpackage

// File: rtl/srch_ctrl.sv
// Period and channel control. Counts spectra within an integration period,
// tracks the channel of each accepted beat, captures settings at period start
// and decides whether a finished spectrum can be captured or must be dropped.
// Assumes each spectrum is NCH beats with the start marker on channel 0.
module srch_ctrl #(
    parameter int NCH   = 64,
    parameter int CNT_W = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sos,
    input  logic [CNT_W-1:0] cfg_nint,
    input  logic [CNT_W-1:0] cfg_min_nint,
    input  logic [1:0]       cfg_trunc,
    input  logic [1:0]       cfg_nprod,
    input  logic             buf_free,
    output logic             beat_ok,
    output logic [CH_W-1:0]  beat_ch,
    output logic             beat_first,
    output logic             beat_cap,
    output logic             beat_last_ch,
    output logic [1:0]       per_trunc,
    output logic [1:0]       per_nprod,
    output logic             ovf_flag
);
    logic             active;
    logic             in_period;
    logic [CH_W-1:0]  ch_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W-1:0] per_len;
    logic             cur_first;
    logic             cur_cap;

    logic [CNT_W-1:0] n_raw, n_eff, idx_n, len_n;
    logic             new_per, final_n;

    // Effective count and next-spectrum decisions at a start marker.
    always_comb begin
        n_raw   = (cfg_nint > cfg_min_nint) ? cfg_nint : cfg_min_nint;
        n_eff   = (n_raw == '0) ? CNT_W'(1) : n_raw;
        new_per = !in_period || (n_eff != per_len) ||
                  (cfg_trunc != per_trunc) || (cfg_nprod != per_nprod);
        idx_n   = new_per ? '0 : per_cnt;
        len_n   = new_per ? n_eff : per_len;
        final_n = (idx_n == len_n - CNT_W'(1));
    end

    // Per-beat qualifiers; a start beat uses the freshly computed values.
    always_comb begin
        beat_ok      = in_valid && (in_sos || active);
        beat_ch      = in_sos ? '0 : ch_cnt;
        beat_first   = in_sos ? (idx_n == '0) : cur_first;
        beat_cap     = in_sos ? (final_n && buf_free) : cur_cap;
        beat_last_ch = (beat_ch == CH_W'(NCH - 1));
    end

    // Channel tracking within a spectrum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ch_cnt <= '0;
        end else if (beat_ok) begin
            active <= !beat_last_ch;
            ch_cnt <= beat_last_ch ? '0 : beat_ch + CH_W'(1);
        end
    end

    // Period bookkeeping, settings capture and overflow latch at start markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_period <= 1'b0;
            per_cnt   <= '0;
            per_len   <= '0;
            per_trunc <= '0;
            per_nprod <= '0;
            cur_first <= 1'b0;
            cur_cap   <= 1'b0;
            ovf_flag  <= 1'b0;
        end else if (beat_ok && in_sos) begin
            if (new_per) begin
                per_len   <= n_eff;
                per_trunc <= cfg_trunc;
                per_nprod <= cfg_nprod;
            end
            per_cnt   <= idx_n + CNT_W'(1);
            in_period <= !final_n;
            cur_first <= (idx_n == '0);
            cur_cap   <= final_n && buf_free;
            if (final_n && !buf_free)
                ovf_flag <= 1'b1;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R10
endmodule

// File: rtl/srch_acc.sv
// Accumulator bank: one 24-bit saturating sum per channel and product.
// On an accepted beat the selected channel is overwritten with the input
// (first spectrum of a period) or has the input added. The resulting sum
// is also presented combinationally for capture.
module srch_acc
    import srch_pkg::*;
#(
    parameter int NCH  = 64,
    parameter int IN_W = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CH_W-1:0]       wr_ch,
    input  logic                  wr_first,
    input  logic [N_PROD*IN_W-1:0] din,
    output acc_t [N_PROD-1:0]     sum
);
    for (genvar p = 0; p < N_PROD; p++) begin : g_prod
        acc_t bank [NCH];
        acc_t old_v;
        acc_t ext_v;

        // Read the stored sum, sign-extend the input and form the new sum.
        always_comb begin
            old_v  = bank[wr_ch];
            ext_v  = acc_t'($signed(din[p*IN_W +: IN_W]));
            sum[p] = wr_first ? ext_v : sat_add(old_v, ext_v);
        end

        // Store the new sum for the beat's channel.
        always_ff @(posedge clk) begin
            if (wr_en)
                bank[wr_ch] <= sum[p];
        end

        AST_SAT_POS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_first && !old_v[ACC_W-1] && !ext_v[ACC_W-1]) |-> !sum[p][ACC_W-1]); // R4
    end
endmodule

// File: rtl/srch_dump.sv
// Output buffer and serializer. Holds one captured spectrum, then sends the
// selected products of each channel, truncated, over valid/ready. The buffer
// is free again on the handshake of the last word of that spectrum.
module srch_dump
    import srch_pkg::*;
#(
    parameter int NCH  = 64,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_last,
    input  acc_t [N_PROD-1:0] wr_data,
    input  logic [1:0]        set_trunc,
    input  logic [1:0]        set_nprod,
    input  logic              out_ready,
    output logic              out_valid,
    output acc_t              out_data,
    output logic              out_last,
    output logic              buf_free
);
    logic             buf_full;
    logic [CH_W-1:0]  rd_ch;
    logic [1:0]       rd_p;
    logic [1:0]       o_trunc;
    logic [1:0]       o_nprod;
    logic [1:0]       p_last;
    acc_t [N_PROD-1:0] rd_val;
    logic             hs;

    for (genvar p = 0; p < N_PROD; p++) begin : g_buf
        acc_t bank [NCH];

        // Capture the finished sum of this product.
        always_ff @(posedge clk) begin
            if (wr_en)
                bank[wr_ch] <= wr_data[p];
        end

        assign rd_val[p] = bank[rd_ch];
    end

    // Output word selection and framing.
    always_comb begin
        p_last    = (o_nprod == 2'd0) ? 2'd0 : (o_nprod == 2'd1) ? 2'd1 : 2'd3;
        out_valid = buf_full;
        out_data  = trunc_val(rd_val[rd_p], o_trunc);
        out_last  = buf_full && (rd_ch == CH_W'(NCH - 1)) && (rd_p == p_last);
        hs        = out_valid && out_ready;
        buf_free  = !buf_full || (hs && out_last);
    end

    // Read pointer advance and buffer occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            rd_ch    <= '0;
            rd_p     <= '0;
            o_trunc  <= '0;
            o_nprod  <= '0;
        end else begin
            if (hs) begin
                if (out_last) begin
                    buf_full <= 1'b0;
                end else if (rd_p == p_last) begin
                    rd_p  <= '0;
                    rd_ch <= rd_ch + CH_W'(1);
                end else begin
                    rd_p <= rd_p + 2'd1;
                end
            end
            if (wr_en && wr_last) begin
                buf_full <= 1'b1;
                rd_ch    <= '0;
                rd_p     <= '0;
                o_trunc  <= set_trunc;
                o_nprod  <= set_nprod;
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
    AST_TRUNC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && o_trunc[1]) |-> ($signed(out_data) >= -128 && $signed(out_data) <= 127)); // R5
    AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> buf_free); // R10
endmodule

// File: rtl/srch_integrator.sv
// Search-mode integrator top. Sums per-channel correlation products over a
// programmable number of spectra, then streams the truncated, product-selected
// result out over valid/ready. Assumes channel-ordered input with a start
// marker on channel 0 and exactly NCH channels per spectrum.
module srch_integrator
    import srch_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int IN_W  = 16,
    parameter int CNT_W = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sos,
    input  logic [IN_W-1:0]  in_xx,
    input  logic [IN_W-1:0]  in_yy,
    input  logic [IN_W-1:0]  in_re,
    input  logic [IN_W-1:0]  in_im,
    input  logic [CNT_W-1:0] cfg_nint,
    input  logic [CNT_W-1:0] cfg_min_nint,
    input  logic [1:0]       cfg_trunc,
    input  logic [1:0]       cfg_nprod,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [23:0]      out_data,
    output logic             out_last,
    output logic             ovf_flag
);
    logic              beat_ok, beat_first, beat_cap, beat_last_ch, buf_free;
    logic [CH_W-1:0]   beat_ch;
    logic [1:0]        per_trunc, per_nprod;
    acc_t [N_PROD-1:0] sums;
    acc_t              o_word;

    srch_ctrl #(.NCH(NCH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
        .cfg_nint(cfg_nint), .cfg_min_nint(cfg_min_nint),
        .cfg_trunc(cfg_trunc), .cfg_nprod(cfg_nprod), .buf_free(buf_free),
        .beat_ok(beat_ok), .beat_ch(beat_ch), .beat_first(beat_first),
        .beat_cap(beat_cap), .beat_last_ch(beat_last_ch),
        .per_trunc(per_trunc), .per_nprod(per_nprod), .ovf_flag(ovf_flag)
    );

    srch_acc #(.NCH(NCH), .IN_W(IN_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .wr_en(beat_ok), .wr_ch(beat_ch),
        .wr_first(beat_first), .din({in_im, in_re, in_yy, in_xx}), .sum(sums)
    );

    srch_dump #(.NCH(NCH)) u_dump (
        .clk(clk), .rst_n(rst_n), .wr_en(beat_ok && beat_cap), .wr_ch(beat_ch),
        .wr_last(beat_last_ch), .wr_data(sums), .set_trunc(per_trunc),
        .set_nprod(per_nprod), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(o_word), .out_last(out_last), .buf_free(buf_free)
    );

    assign out_data = o_word;
endmodule

// File: tb/srch_integrator_bench.sv
module srch_integrator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int IN_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sos = 1'b0;
    logic [IN_W-1:0] in_xx = '0, in_yy = '0, in_re = '0, in_im = '0;
    logic [15:0] cfg_nint = 16'd1, cfg_min_nint = 16'd1;
    logic [1:0]  cfg_trunc = 2'd0, cfg_nprod = 2'd2;
    logic out_valid, out_ready = 1'b1, out_last, ovf_flag;
    logic [23:0] out_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    longint exp_q[$];
    bit     last_q[$];

    longint m_acc [NCH][4];
    bit m_inper = 0;
    int m_cnt = 0, m_len = 0, m_tr = 0, m_np = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srch_integrator #(.NCH(NCH), .IN_W(IN_W), .CNT_W(16)) u_srch_integrator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
        .in_xx(in_xx), .in_yy(in_yy), .in_re(in_re), .in_im(in_im),
        .cfg_nint(cfg_nint), .cfg_min_nint(cfg_min_nint),
        .cfg_trunc(cfg_trunc), .cfg_nprod(cfg_nprod),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic longint clamp24(input longint v);
        if (v > 8388607) return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    function automatic longint trunc_ref(input longint v, input int code);
        if (code == 0) return v;
        if (code == 1) return v / 256;
        return v / 65536;
    endfunction

    // Monitor: pop and compare each word on handshake.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected word", longint'($signed(out_data)), 0);
            end else begin
                longint e;
                bit l;
                e = exp_q.pop_front();
                l = last_q.pop_front();
                check(longint'($signed(out_data)) == e, "R2/R4/R5 data", longint'($signed(out_data)), e);
                check(out_last == l, "R6 last", longint'(out_last), longint'(l));
            end
        end
    end

    // Driver: one spectrum; model updates and pushes expected words.
    task automatic spectrum(input int base, input bit big, input bit gaps, input bit drop);
        int neff, idx, k;
        bit newp, first, fin;
        neff = (cfg_nint > cfg_min_nint) ? int'(cfg_nint) : int'(cfg_min_nint);
        if (neff == 0) neff = 1;
        newp = !m_inper || neff != m_len || int'(cfg_trunc) != m_tr || int'(cfg_nprod) != m_np;
        if (newp) begin
            m_len = neff; m_tr = cfg_trunc; m_np = cfg_nprod; m_cnt = 0;
        end
        idx = m_cnt; first = (idx == 0); fin = (idx == m_len - 1);
        m_cnt = idx + 1; m_inper = !fin;
        for (int ch = 0; ch < NCH; ch++)
            for (int p = 0; p < 4; p++) begin
                longint v;
                v = big ? ((p % 2 == 0) ? 32767 : -32768) : base + 13*ch - 40*p;
                m_acc[ch][p] = first ? v : clamp24(m_acc[ch][p] + v);
            end
        if (fin && !drop) begin
            k = (m_np == 0) ? 1 : (m_np == 1) ? 2 : 4;
            for (int ch = 0; ch < NCH; ch++)
                for (int p = 0; p < k; p++) begin
                    exp_q.push_back(trunc_ref(m_acc[ch][p], m_tr));
                    last_q.push_back(ch == NCH-1 && p == k-1);
                end
        end
        for (int ch = 0; ch < NCH; ch++) begin
            int v0, v1, v2, v3;
            v0 = big ? 32767 : base + 13*ch;
            v1 = big ? -32768 : base + 13*ch - 40;
            v2 = big ? 32767 : base + 13*ch - 80;
            v3 = big ? -32768 : base + 13*ch - 120;
            @(posedge clk); #1;
            in_valid = 1; in_sos = (ch == 0);
            in_xx = IN_W'(v0); in_yy = IN_W'(v1); in_re = IN_W'(v2); in_im = IN_W'(v3);
            if (gaps) begin
                @(posedge clk); #1;
                in_valid = 0; in_sos = 1; in_xx = 16'h7abc; in_yy = 16'h1234;
            end
        end
        @(posedge clk); #1;
        in_valid = 0; in_sos = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            if (exp_q.size() == 0 && !out_valid) break;
            @(posedge clk);
        end
        #2;
        check(exp_q.size() == 0, "R2 all words drained", exp_q.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        longint held;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        check(ovf_flag == 0, "R1 ovf_flag after reset", ovf_flag, 0);

        // R8: beats before the first start marker are ignored.
        @(posedge clk); #1;
        in_valid = 1; in_sos = 0; in_xx = 16'h4000; in_yy = 16'h4000;
        @(posedge clk); #1;
        in_valid = 0;

        // R2: two spectra summed, all products, full width, with gaps (R8).
        cfg_nint = 2; cfg_min_nint = 1; cfg_trunc = 0; cfg_nprod = 2;
        spectrum(100, 0, 0, 0);
        spectrum(-50, 0, 1, 0);
        drain();

        // R5 code 1, R6 code 0: three spectra, XX only.
        cfg_nint = 3; cfg_trunc = 1; cfg_nprod = 0;
        spectrum(1000, 0, 0, 0);
        spectrum(-3000, 0, 0, 0);
        spectrum(-900, 0, 0, 0);
        drain();

        // R3: lower bound overrides a smaller count.
        cfg_nint = 1; cfg_min_nint = 3; cfg_trunc = 0; cfg_nprod = 1;
        spectrum(200, 0, 0, 0);
        spectrum(300, 0, 0, 0);
        repeat (3) @(posedge clk);
        #2 check(out_valid == 0, "R3 no output before minimum count", out_valid, 0);
        spectrum(400, 0, 0, 0);
        drain();

        // R7: settings change after one spectrum restarts the period.
        cfg_nint = 3; cfg_min_nint = 1; cfg_nprod = 2;
        spectrum(5000, 0, 0, 0);
        cfg_nprod = 1;
        spectrum(10, 0, 0, 0);
        spectrum(20, 0, 1, 0);
        spectrum(30, 0, 0, 0);
        drain();

        // R4: saturation at full width.
        cfg_nint = 260; cfg_trunc = 0; cfg_nprod = 1;
        for (int i = 0; i < 260; i++) spectrum(0, 1, 0, 0);
        drain();

        // R4 with R5 code 2: saturated sums truncated to 8 bits.
        cfg_nint = 300; cfg_trunc = 2; cfg_nprod = 2;
        for (int i = 0; i < 300; i++) spectrum(0, 1, 0, 0);
        drain();

        // R9, R10: stall, then a spectrum that must be dropped.
        out_ready = 0;
        cfg_nint = 1; cfg_trunc = 0; cfg_nprod = 2;
        spectrum(700, 0, 0, 0);
        @(negedge clk);
        check(out_valid == 1, "R9 valid while stalled", out_valid, 1);
        held = longint'($signed(out_data));
        check(held == exp_q[0], "R9 first word present", held, exp_q[0]);
        repeat (3) @(negedge clk);
        check(out_valid == 1 && longint'($signed(out_data)) == held, "R9 data held", longint'($signed(out_data)), held);
        spectrum(-700, 0, 0, 1);
        @(negedge clk);
        check(ovf_flag == 1, "R10 overflow raised", ovf_flag, 1);
        @(posedge clk); #1 out_ready = 1;
        drain();
        spectrum(77, 0, 0, 0);
        drain();
        check(ovf_flag == 1, "R10 overflow sticky", ovf_flag, 1);

        finish_run();
    end
endmodule